// File: doc/BRIEF.md
# Bucketed Peak / Pit / Sample Detector

This block reduces a stream of digitised samples to one value per display bucket, where a bucket is the run of samples that falls between two adjacent display points. A single holding register keeps the running result of the current bucket. A magnitude comparator checks every incoming sample against the held value. Its greater-than and less-than flags, together with the selected detection mode, form an active-low load enable for that register.

In peak mode the register keeps the largest sample of the bucket. In pit mode it keeps the smallest. In sample mode it keeps the last one. When the stream runs at the full sample rate, the load enable is forced active, so every sample is loaded and stored.

One cycle after the last sample of a bucket, the held value is written into a small capture memory at a write address. That address steps after each write and returns to zero whenever capture mode starts. While capture mode is off, a processor reads the memory through a separate registered read port.

Top module: `bktdet_top`

## Requirements
- R1: With `det_mode` = 2'b01 (peak), the held value at the end of a bucket is the largest valid sample of that bucket.
- R2: With `det_mode` = 2'b10 (pit), the held value at the end of a bucket is the smallest valid sample of that bucket.
- R3: With `det_mode` = 2'b00 (sample), every valid sample is loaded, so the held value at the end of a bucket is its last sample.
- R4: A valid sample with `bkt_first` high loads the register whatever the mode or the comparison result, so one bucket's result never carries into the next.
- R5: While `smp_valid` is low, the held value does not change.
- R6: With `full_rate` high, every valid sample is loaded in any mode and is written to memory, one entry per sample.
- R7: Suppose a valid sample with `bkt_last` high (or any valid sample at full rate) arrives while `capture` is high. Then `wr_strobe` is high in the next cycle. At that cycle's clock edge the held value is stored at `wr_addr`, and `wr_addr` then steps by one, wrapping modulo 2^AW.
- R8: On the first clock edge where `capture` is high after being low, or after reset, `wr_addr` returns to zero.
- R9: While `capture` is low, buckets that complete produce no write strobe and leave `wr_addr` unchanged.
- R10: One cycle after a `cpu_addr` is presented with `capture` low, `cpu_rdata` shows that memory entry. While `capture` is high, `cpu_rdata` reads zero.
- R11: A synchronous reset clears the held value, the write address, the pending write and the capture state.
- R12: `det_mode` = 2'b11 behaves the same as sample mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW | Sample value, unsigned |
| bkt_first | input | 1 | Marks the first sample of a bucket |
| bkt_last | input | 1 | Marks the last sample of a bucket |
| det_mode | input | 2 | 00 sample, 01 peak, 10 pit, 11 sample |
| full_rate | input | 1 | Full-rate flag: forces every sample through |
| capture | input | 1 | Capture mode level |
| cpu_addr | input | AW | Processor read address |
| cpu_rdata | output | DW | Registered processor read data |
| hold_q | output | DW | Current held value |
| wr_strobe | output | 1 | Memory write pulse |
| wr_addr | output | AW | Current memory write address |

## Verification
The bench places duplicate extremes and smaller trailing samples in peak and pit buckets. A detector that picked the first or last sample, or that swapped the sense of the comparator, would store a wrong value. A large peak followed by a small bucket tests the bucket-start reload: without it, the old peak would persist. Full-rate runs in pit mode show whether the forced enable overrides the comparator. A wrong address step or a missing wrap would put entries in the wrong places. Idle-capture buckets, reads taken during capture and a capture restart expose writes that are not gated, stale read data and an address that never returns to zero.

// File: rtl/bktdet_pkg.sv
`timescale 1ns/1ps
package bktdet_pkg;
   typedef enum logic [1:0] {
      DM_SAMPLE = 2'b00,
      DM_PEAK   = 2'b01,
      DM_PIT    = 2'b10,
      DM_ALT    = 2'b11
   } det_mode_e;
endpackage

// File: rtl/bktdet_cmp.sv
`timescale 1ns/1ps
// Unsigned magnitude comparator: gt_flag when a > b, lt_flag when a < b,
// both low when equal.
module bktdet_cmp #(
   parameter int DW    = 8,
   parameter int STYLE = 0
) (
   input  logic [DW-1:0] a_in,
   input  logic [DW-1:0] b_in,
   output logic          gt_flag,
   output logic          lt_flag
);
   generate
      if (STYLE == 0) begin : g_rel
         assign gt_flag = (a_in > b_in);
         assign lt_flag = (a_in < b_in);
      end else begin : g_scan
         // MSB-first scan: the first differing bit decides
         always_comb begin
            logic decided;
            decided = 1'b0;
            gt_flag = 1'b0;
            lt_flag = 1'b0;
            for (int i = DW-1; i >= 0; i--) begin
               if (!decided && (a_in[i] != b_in[i])) begin
                  gt_flag = a_in[i];
                  lt_flag = b_in[i];
                  decided = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/bktdet_hold.sv
`timescale 1ns/1ps
module bktdet_hold
   import bktdet_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          smp_valid,
   input  logic [DW-1:0] smp_data,
   input  logic          bkt_first,
   input  logic [1:0]    mode,
   input  logic          full_rate,
   input  logic          in_gt,
   input  logic          in_lt,
   output logic [DW-1:0] hold_q
);
   det_mode_e md;
   logic      take;
   logic      load_n;

   assign md = det_mode_e'(mode);

   always_comb begin
      if (full_rate || bkt_first) begin
         take = 1'b1;
      end else begin
         case (md)
            DM_PEAK: take = in_gt;
            DM_PIT:  take = in_lt;
            default: take = 1'b1;
         endcase
      end
   end

   assign load_n = ~take;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= '0;
      end else if (smp_valid && !load_n) begin
         hold_q <= smp_data;
      end
   end

   // R1
   peak_mono_chk: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && !bkt_first && !full_rate && md == DM_PEAK) |=> hold_q >= $past(hold_q));
   // R2
   pit_mono_chk: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && !bkt_first && !full_rate && md == DM_PIT) |=> hold_q <= $past(hold_q));
   // R3
   sample_load_chk: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && md == DM_SAMPLE) |=> hold_q == $past(smp_data));
   // R4
   first_load_chk: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && bkt_first) |=> hold_q == $past(smp_data));
   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !smp_valid |=> $stable(hold_q));
   // R6
   full_rate_chk: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && full_rate) |=> hold_q == $past(smp_data));
endmodule

// File: rtl/bktdet_wctl.sv
`timescale 1ns/1ps
module bktdet_wctl #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          capture,
   input  logic          smp_valid,
   input  logic          bkt_last,
   input  logic          full_rate,
   output logic          wr_pend,
   output logic [AW-1:0] wr_addr
);
   logic cap_q;
   logic cap_rise;

   assign cap_rise = capture && !cap_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_q   <= 1'b0;
         wr_pend <= 1'b0;
         wr_addr <= '0;
      end else begin
         cap_q   <= capture;
         wr_pend <= capture && smp_valid && (bkt_last || full_rate);
         if (cap_rise) begin
            wr_addr <= '0;
         end else if (wr_pend) begin
            wr_addr <= wr_addr + AW'(1);
         end
      end
   end

   // R7
   addr_step_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_pend && !cap_rise) |=> wr_addr == AW'($past(wr_addr) + AW'(1)));
   // R8
   cap_start_chk: assert property (@(posedge clk) disable iff (rst)
      cap_rise |=> wr_addr == '0);
   // R9
   no_idle_write_chk: assert property (@(posedge clk) disable iff (rst)
      !capture |=> !wr_pend);
endmodule

// File: rtl/bktdet_capmem.sv
`timescale 1ns/1ps
module bktdet_capmem #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rd_block,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rd_block) begin
         rdata <= '0;
      end else begin
         rdata <= mem[raddr];
      end
   end
endmodule

// File: rtl/bktdet_top.sv
`timescale 1ns/1ps
module bktdet_top #(
   parameter int DW        = 8,
   parameter int AW        = 4,
   parameter int CMP_STYLE = 0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          smp_valid,
   input  logic [DW-1:0] smp_data,
   input  logic          bkt_first,
   input  logic          bkt_last,
   input  logic [1:0]    det_mode,
   input  logic          full_rate,
   input  logic          capture,
   input  logic [AW-1:0] cpu_addr,
   output logic [DW-1:0] cpu_rdata,
   output logic [DW-1:0] hold_q,
   output logic          wr_strobe,
   output logic [AW-1:0] wr_addr
);
   generate
      if (DW < 2 || DW > 32) begin : g_bad_dw
         $error("bktdet_top: DW out of range");
      end
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("bktdet_top: AW out of range");
      end
      if (CMP_STYLE < 0 || CMP_STYLE > 1) begin : g_bad_style
         $error("bktdet_top: CMP_STYLE must be 0 or 1");
      end
   endgenerate

   logic in_gt;
   logic in_lt;

   bktdet_cmp #(.DW(DW), .STYLE(CMP_STYLE)) u_cmp (
      .a_in    (smp_data),
      .b_in    (hold_q),
      .gt_flag (in_gt),
      .lt_flag (in_lt)
   );

   bktdet_hold #(.DW(DW)) u_hold (
      .clk       (clk),
      .rst       (rst),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .bkt_first (bkt_first),
      .mode      (det_mode),
      .full_rate (full_rate),
      .in_gt     (in_gt),
      .in_lt     (in_lt),
      .hold_q    (hold_q)
   );

   bktdet_wctl #(.AW(AW)) u_wctl (
      .clk       (clk),
      .rst       (rst),
      .capture   (capture),
      .smp_valid (smp_valid),
      .bkt_last  (bkt_last),
      .full_rate (full_rate),
      .wr_pend   (wr_strobe),
      .wr_addr   (wr_addr)
   );

   bktdet_capmem #(.DW(DW), .AW(AW)) u_mem (
      .clk      (clk),
      .we       (wr_strobe),
      .waddr    (wr_addr),
      .wdata    (hold_q),
      .rd_block (capture),
      .raddr    (cpu_addr),
      .rdata    (cpu_rdata)
   );

   // R11
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (hold_q == '0 && wr_addr == '0 && !wr_strobe));
   // R10
   rd_block_chk: assert property (@(posedge clk) disable iff (rst)
      capture |=> cpu_rdata == '0);
endmodule

// File: tb/test_bktdet_top.sv
`timescale 1ns/1ps
module test_bktdet_top;
   localparam int DW = 8;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          smp_valid = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic          bkt_first = 1'b0;
   logic          bkt_last = 1'b0;
   logic [1:0]    det_mode = 2'b00;
   logic          full_rate = 1'b0;
   logic          capture = 1'b1;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_rdata;
   logic [DW-1:0] hold_q;
   logic          wr_strobe;
   logic [AW-1:0] wr_addr;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   bktdet_top #(.DW(DW), .AW(AW)) i_bktdet_top (
      .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
      .bkt_first(bkt_first), .bkt_last(bkt_last), .det_mode(det_mode),
      .full_rate(full_rate), .capture(capture), .cpu_addr(cpu_addr),
      .cpu_rdata(cpu_rdata), .hold_q(hold_q), .wr_strobe(wr_strobe),
      .wr_addr(wr_addr)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one valid sample; returns at the falling edge after it was taken
   task automatic put(input int d, input bit first, input bit last);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = DW'(d);
      bkt_first = first;
      bkt_last  = last;
      @(negedge clk);
      smp_valid = 1'b0;
      bkt_first = 1'b0;
      bkt_last  = 1'b0;
   endtask

   task automatic bucket(input int v[], input string req, input int exp);
      for (int i = 0; i < v.size(); i++) begin
         put(v[i], i == 0, i == v.size() - 1);
      end
      chk(req, hold_q, exp);
      chk("R7 strobe", wr_strobe, 1);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic rd(input int a, input string req, input int exp);
      @(negedge clk);
      cpu_addr = AW'(a);
      @(negedge clk);
      chk(req, cpu_rdata, exp);
   endtask

   task automatic t_reset();
      idle(3);
      rst = 1'b0;
      chk("R11 held", hold_q, 0);
      chk("R11 addr", wr_addr, 0);
      chk("R11 strobe", wr_strobe, 0);
   endtask

   task automatic t_modes();
      det_mode = 2'b01;
      bucket('{30, 200, 90, 200, 10}, "R1 peak", 200);
      idle(1);
      chk("R7 addr step", wr_addr, 1);
      det_mode = 2'b10;
      bucket('{100, 40, 250, 40, 77}, "R2 pit", 40);
      det_mode = 2'b00;
      bucket('{5, 99, 3}, "R3 sample", 3);
      det_mode = 2'b11;
      bucket('{7, 8, 6}, "R12 alt mode", 6);
   endtask

   task automatic t_restart();
      det_mode = 2'b01;
      bucket('{250}, "R1 single", 250);
      bucket('{12, 15, 9}, "R4 reload", 15);
   endtask

   task automatic t_gaps();
      det_mode = 2'b01;
      put(60, 1'b1, 1'b0);
      idle(3);
      chk("R5 idle hold", hold_q, 60);
      put(20, 1'b0, 1'b1);
      chk("R5 peak after gap", hold_q, 60);
   endtask

   task automatic t_full_rate();
      det_mode = 2'b10;
      full_rate = 1'b1;
      put(50, 1'b0, 1'b0);
      chk("R6 load 50", hold_q, 50);
      put(60, 1'b0, 1'b0);
      chk("R6 load 60", hold_q, 60);
      put(70, 1'b0, 1'b0);
      chk("R6 load 70", hold_q, 70);
      idle(1);
      chk("R6 addr", wr_addr, 10);
      full_rate = 1'b0;
   endtask

   task automatic t_idle_capture();
      capture = 1'b0;
      det_mode = 2'b01;
      idle(1);
      put(1, 1'b1, 1'b0);
      put(2, 1'b0, 1'b1);
      chk("R9 no strobe", wr_strobe, 0);
      idle(1);
      chk("R9 addr held", wr_addr, 10);
   endtask

   task automatic t_readback();
      int exp[10] = '{200, 40, 3, 6, 250, 15, 60, 50, 60, 70};
      for (int a = 0; a < 10; a++) rd(a, "R10 readback", exp[a]);
   endtask

   task automatic t_capture_restart();
      @(negedge clk);
      capture = 1'b1;
      cpu_addr = '0;
      @(negedge clk);
      chk("R10 blocked read", cpu_rdata, 0);
      chk("R8 addr zero", wr_addr, 0);
   endtask

   task automatic t_wrap();
      det_mode = 2'b00;
      full_rate = 1'b1;
      for (int i = 0; i < 17; i++) put(100 + i, 1'b0, 1'b0);
      idle(1);
      chk("R7 wrap addr", wr_addr, 1);
      full_rate = 1'b0;
      capture = 1'b0;
      rd(0, "R7 wrap entry0", 116);
      rd(15, "R7 wrap entry15", 115);
      rd(1, "R7 entry1", 101);
   endtask

   initial begin
      t_reset();
      t_modes();
      t_restart();
      t_gaps();
      t_full_rate();
      t_idle_capture();
      t_readback();
      t_capture_restart();
      t_wrap();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule